// File: doc/BRIEF.md
# Dual-Field Signed-Digit Adder

This block adds or subtracts two operands held in redundant signed-digit form. Each digit position carries a plus bit and a minus bit, and the value of the digit is the plus bit minus the minus bit. A field-select input sets the arithmetic. In prime-field mode the block adds integers and carries ripple one position per adder layer. In binary-extension-field mode every carry is held at zero, so the result is the coefficient-wise sum modulo 2.

The datapath has two cascaded layers of generalized full adders. The first layer merges the first operand with the plus bits of the second operand. The second layer folds in the minus bits of the second operand. A cleanup stage then rewrites any digit whose plus and minus bits are both set. To subtract, the second operand's plus and minus vectors are exchanged, so the same adder does both jobs. A sign detector reads the cleaned result and reports whether it is zero, positive or negative without any two's-complement step. A parameter chooses between a purely combinational output and a registered one.

Top module: `sdDualFieldAdder`

## Requirements
- R1: Digit i of an operand or result has weight 2^i. Bit i of its plus vector and bit i of its minus vector encode the digit as (plus,minus): (0,0)=0, (1,0)=+1, (0,1)=-1. With fieldSel=1 and subEn=0, value(sumPos,sumNeg) equals value(aPos,aNeg)+value(bPos,bNeg) exactly.
- R2: With fieldSel=1 and subEn=1, value(sumPos,sumNeg) equals value(aPos,aNeg)-value(bPos,bNeg) exactly.
- R3: No result digit has both its plus and its minus bit set, in either mode.
- R4: With fieldSel=0, sumNeg is all zero and the two top result positions (WIDTH and WIDTH+1) are zero. For operands whose minus vectors are zero, sumPos[WIDTH-1:0] equals aPos XOR bPos, whether subEn is 0 or 1.
- R5: cmpCode is 2'b00 when every result digit is zero. It is 2'b01 when the most significant nonzero result digit is (1,0), and 2'b10 when that digit is (0,1). The value 2'b11 never appears.
- R6: With REG_OUT=1, the outputs show the result for the inputs present at a rising clock edge and hold it until the next edge. With REG_OUT=0, the outputs follow the inputs combinationally.
- R7: While rstN is low, the registered outputs are zero and cmpCode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldSel | input | 1 | 1 = prime-field integer mode, 0 = binary-field carry-free mode |
| subEn | input | 1 | 1 = subtract second operand, 0 = add |
| aPos | input | WIDTH | Plus bits of first operand |
| aNeg | input | WIDTH | Minus bits of first operand |
| bPos | input | WIDTH | Plus bits of second operand |
| bNeg | input | WIDTH | Minus bits of second operand |
| sumPos | output | WIDTH+2 | Plus bits of result |
| sumNeg | output | WIDTH+2 | Minus bits of result |
| cmpCode | output | 2 | Sign of result: 00 zero, 01 positive, 10 negative |

## Verification
The result is compared in the first registered cycle after each input vector. A wrong carry-enable, a swapped operand or a missed cleanup therefore appears on the very next clock, as a result value off by a power of two, as a nonzero minus vector in binary mode, or as a (1,1) digit. A wrong decision in the sign detector shows up as a cmpCode that disagrees with the sign of the integer the bench computes for the same vector. The sweep covers every legal three-valued digit pattern of a four-digit configuration, in both operations, so every carry chain and every cancellation path is exercised.

// File: rtl/sdAdderPkg.sv
package sdAdderPkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic carryEn;  // 1: integer carries propagate, 0: carries held at zero
    logic swapB;    // 1: exchange plus/minus vectors of operand b (subtract)
  } sdStrobes_t;

  // Sign code of the cleaned result
  typedef enum logic [1:0] {
    CMP_ZERO = 2'b00,
    CMP_POS  = 2'b01,
    CMP_NEG  = 2'b10
  } sdCmp_e;

endpackage

// File: rtl/sdGfa.sv
// Generalized full adder cell. With inputs weighted (+x, -y, +z) it yields
// x - y + z = 2*carryOut - sumOut. With the signs of all inputs flipped, the
// same equation read negated gives the other cell type (-x + y - z).
// carryEn=0 forces the carry low; the sum is then the XOR of the three inputs.
module sdGfa (
  input  logic xIn,
  input  logic yIn,
  input  logic zIn,
  input  logic carryEn,
  output logic carryOut,
  output logic sumOut
);

  logic yInv;

  assign yInv     = ~yIn;
  assign sumOut   = xIn ^ yIn ^ zIn;
  assign carryOut = carryEn & ((xIn & yInv) | (xIn & zIn) | (yInv & zIn));

endmodule

// File: rtl/sdControl.sv
// Turns the mode and operation pins into datapath strobes.
module sdControl
  import sdAdderPkg::*;
(
  input  logic       fieldSel,
  input  logic       subEn,
  output sdStrobes_t strobes
);

  always_comb begin
    strobes.carryEn = fieldSel;
    strobes.swapB   = subEn;
  end

endmodule

// File: rtl/sdDatapath.sv
// Two layers of generalized full adders followed by digit cleanup.
module sdDatapath
  import sdAdderPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  sdStrobes_t        strobes,
  input  logic [WIDTH-1:0]  aPos,
  input  logic [WIDTH-1:0]  aNeg,
  input  logic [WIDTH-1:0]  bPos,
  input  logic [WIDTH-1:0]  bNeg,
  output logic [WIDTH+1:0]  resPos,
  output logic [WIDTH+1:0]  resNeg
);

  localparam int L2W  = WIDTH + 1;  // second layer spans one extra position
  localparam int RESW = WIDTH + 2;  // result keeps both top carries

  logic [WIDTH-1:0] opPos;
  logic [WIDTH-1:0] opNeg;

  // Subtraction: exchange the second operand's plus and minus vectors
  assign opPos = strobes.swapB ? bNeg : bPos;
  assign opNeg = strobes.swapB ? bPos : bNeg;

  // Layer one: aPos (+) , aNeg (-) , opPos (+)  -> c1 (+, weight i+1), s1 (-, weight i)
  logic [WIDTH-1:0] c1;
  logic [WIDTH-1:0] s1;

  for (genvar i = 0; i < WIDTH; i++) begin : gLayerOne
    sdGfa uCell (
      .xIn     (aPos[i]),
      .yIn     (aNeg[i]),
      .zIn     (opPos[i]),
      .carryEn (strobes.carryEn),
      .carryOut(c1[i]),
      .sumOut  (s1[i])
    );
  end

  // Layer two: s1 (-) , shifted c1 (+) , opNeg (-) -> c2 (-, weight i+1), s2 (+, weight i)
  logic [L2W-1:0] s1Ext;
  logic [L2W-1:0] c1Shift;
  logic [L2W-1:0] opNegExt;
  logic [L2W-1:0] c2;
  logic [L2W-1:0] s2;

  assign s1Ext    = {1'b0, s1};
  assign c1Shift  = {c1, 1'b0};
  assign opNegExt = {1'b0, opNeg};

  for (genvar i = 0; i < L2W; i++) begin : gLayerTwo
    sdGfa uCell (
      .xIn     (s1Ext[i]),
      .yIn     (c1Shift[i]),
      .zIn     (opNegExt[i]),
      .carryEn (strobes.carryEn),
      .carryOut(c2[i]),
      .sumOut  (s2[i])
    );
  end

  // Raw digits: plus from layer-two sums, minus from layer-two carries
  logic [RESW-1:0] rawPos;
  logic [RESW-1:0] rawNeg;

  assign rawPos = {1'b0, s2};
  assign rawNeg = {c2, 1'b0};

  // Cleanup: a digit (1,1) is worth zero and is rewritten as (0,0)
  for (genvar i = 0; i < RESW; i++) begin : gCleanup
    logic cancel;
    assign cancel    = rawPos[i] & rawNeg[i];
    assign resPos[i] = rawPos[i] & ~cancel;
    assign resNeg[i] = rawNeg[i] & ~cancel;
  end

endmodule

// File: rtl/sdSignDetect.sv
// Reports the sign of a cleaned signed-digit vector from its leading nonzero digit.
module sdSignDetect
  import sdAdderPkg::*;
#(
  parameter int DIGITS = 10
) (
  input  logic [DIGITS-1:0] digPos,
  input  logic [DIGITS-1:0] digNeg,
  output sdCmp_e            cmp
);

  // Scan upward; each nonzero digit overrides what lies below it
  always_comb begin
    cmp = CMP_ZERO;
    for (int i = 0; i < DIGITS; i++) begin
      if (digPos[i]) begin
        cmp = CMP_POS;
      end else if (digNeg[i]) begin
        cmp = CMP_NEG;
      end
    end
  end

endmodule

// File: rtl/sdDualFieldAdder.sv
module sdDualFieldAdder
  import sdAdderPkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fieldSel,
  input  logic             subEn,
  input  logic [WIDTH-1:0] aPos,
  input  logic [WIDTH-1:0] aNeg,
  input  logic [WIDTH-1:0] bPos,
  input  logic [WIDTH-1:0] bNeg,
  output logic [WIDTH+1:0] sumPos,
  output logic [WIDTH+1:0] sumNeg,
  output logic [1:0]       cmpCode
);

  localparam int RESW = WIDTH + 2;

  sdStrobes_t      strobes;
  logic [RESW-1:0] nextPos;
  logic [RESW-1:0] nextNeg;
  sdCmp_e          nextCmp;

  sdControl uCtrl (
    .fieldSel(fieldSel),
    .subEn   (subEn),
    .strobes (strobes)
  );

  sdDatapath #(.WIDTH(WIDTH)) uPath (
    .strobes(strobes),
    .aPos   (aPos),
    .aNeg   (aNeg),
    .bPos   (bPos),
    .bNeg   (bNeg),
    .resPos (nextPos),
    .resNeg (nextNeg)
  );

  sdSignDetect #(.DIGITS(RESW)) uSign (
    .digPos(nextPos),
    .digNeg(nextNeg),
    .cmp   (nextCmp)
  );

  if (REG_OUT) begin : gRegOut
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sumPos  <= '0;
        sumNeg  <= '0;
        cmpCode <= CMP_ZERO;
      end else begin
        sumPos  <= nextPos;
        sumNeg  <= nextNeg;
        cmpCode <= nextCmp;
      end
    end
  end else begin : gCombOut
    assign sumPos  = nextPos;
    assign sumNeg  = nextNeg;
    assign cmpCode = nextCmp;
  end

endmodule

// File: rtl/sdDualFieldAdderChk.sv
module sdDualFieldAdderChk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             fieldSel,
  input logic             subEn,
  input logic [WIDTH-1:0] aPos,
  input logic [WIDTH-1:0] aNeg,
  input logic [WIDTH-1:0] bPos,
  input logic [WIDTH-1:0] bNeg,
  input logic [WIDTH+1:0] sumPos,
  input logic [WIDTH+1:0] sumNeg,
  input logic [1:0]       cmpCode
);

  localparam int VW = WIDTH + 3;

  // Inputs aligned with the outputs they produced
  logic             readyQ;
  logic             modeU;
  logic             subU;
  logic [WIDTH-1:0] aPosU, aNegU, bPosU, bNegU;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  if (REG_OUT) begin : gAlignReg
    always_ff @(posedge clk) begin
      modeU <= fieldSel;
      subU  <= subEn;
      aPosU <= aPos;
      aNegU <= aNeg;
      bPosU <= bPos;
      bNegU <= bNeg;
    end
  end else begin : gAlignComb
    assign modeU = fieldSel;
    assign subU  = subEn;
    assign aPosU = aPos;
    assign aNegU = aNeg;
    assign bPosU = bPos;
    assign bNegU = bNeg;
  end

  logic signed [VW-1:0] aVal, bVal, expVal, gotVal;

  assign aVal   = $signed({3'b000, aPosU}) - $signed({3'b000, aNegU});
  assign bVal   = $signed({3'b000, bPosU}) - $signed({3'b000, bNegU});
  assign expVal = subU ? (aVal - bVal) : (aVal + bVal);
  assign gotVal = $signed({1'b0, sumPos}) - $signed({1'b0, sumNeg});

  // R3
  no_double_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sumPos & sumNeg) == '0);

  // R5
  cmp_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmpCode != 2'b11);

  // R5
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpCode == 2'b00) == ((sumPos == '0) && (sumNeg == '0)));

  // R1 and R2
  prime_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyQ && modeU) |-> (gotVal == expVal));

  // R4
  binary_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readyQ && !modeU) |->
      ((sumNeg == '0) && (sumPos == {2'b00, aPosU ^ aNegU ^ bPosU ^ bNegU})));

endmodule

bind sdDualFieldAdder sdDualFieldAdderChk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .fieldSel(fieldSel),
  .subEn   (subEn),
  .aPos    (aPos),
  .aNeg    (aNeg),
  .bPos    (bPos),
  .bNeg    (bNeg),
  .sumPos  (sumPos),
  .sumNeg  (sumNeg),
  .cmpCode (cmpCode)
);

// File: tb/sdDualFieldAdder_test.sv
`timescale 1ns/1ps
module sdDualFieldAdder_test;

  localparam int W     = 4;
  localparam int CODES = 81;  // 3^W legal digit patterns

  logic         clk = 1'b0;
  logic         rstN;
  logic         fieldSel, subEn;
  logic [W-1:0] aPos, aNeg, bPos, bNeg;
  logic [W+1:0] sumPos, sumNeg;
  logic [1:0]   cmpCode;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sdDualFieldAdder #(.WIDTH(W), .REG_OUT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .fieldSel(fieldSel), .subEn(subEn),
    .aPos(aPos), .aNeg(aNeg), .bPos(bPos), .bNeg(bNeg),
    .sumPos(sumPos), .sumNeg(sumNeg), .cmpCode(cmpCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // base-3 code -> digits: 0 -> (0,0), 1 -> (1,0), 2 -> (0,1)
  function automatic void decode(input int code, output logic [W-1:0] p, output logic [W-1:0] n);
    int c = code;
    p = '0;
    n = '0;
    for (int i = 0; i < W; i++) begin
      if (c % 3 == 1) p[i] = 1'b1;
      if (c % 3 == 2) n[i] = 1'b1;
      c = c / 3;
    end
  endfunction

  function automatic int resVal();
    return int'(sumPos) - int'(sumNeg);
  endfunction

  // Drive one vector at a falling edge, check one cycle later at the next falling edge
  task automatic runPrime(input bit sub, input logic [W-1:0] ap, input logic [W-1:0] an,
                          input logic [W-1:0] bp, input logic [W-1:0] bn);
    int expV;
    int expC;
    fieldSel = 1'b1; subEn = sub;
    aPos = ap; aNeg = an; bPos = bp; bNeg = bn;
    @(posedge clk);
    @(negedge clk);
    expV = sub ? ((int'(ap) - int'(an)) - (int'(bp) - int'(bn)))
               : ((int'(ap) - int'(an)) + (int'(bp) - int'(bn)));
    expC = (expV == 0) ? 0 : ((expV > 0) ? 1 : 2);
    check(resVal() == expV, sub ? "R2 prime difference" : "R1 prime sum", resVal(), expV);
    check((sumPos & sumNeg) == '0, "R3 no (1,1) digit", int'(sumPos & sumNeg), 0);
    check(int'(cmpCode) == expC, "R5 sign code", int'(cmpCode), expC);
  endtask

  task automatic runBinary(input bit sub, input logic [W-1:0] ap, input logic [W-1:0] bp);
    logic [W+1:0] expP;
    fieldSel = 1'b0; subEn = sub;
    aPos = ap; aNeg = '0; bPos = bp; bNeg = '0;
    @(posedge clk);
    @(negedge clk);
    expP = {2'b00, ap ^ bp};
    check(sumPos == expP, "R4 binary xor", int'(sumPos), int'(expP));
    check(sumNeg == '0, "R4 binary minus zero", int'(sumNeg), 0);
    check(int'(cmpCode) == ((expP != 0) ? 1 : 0), "R5 binary sign code",
          int'(cmpCode), (expP != 0) ? 1 : 0);
  endtask

  initial begin
    logic [W-1:0] ap, an, bp, bn;
    rstN = 1'b0;
    fieldSel = 1'b1; subEn = 1'b0;
    aPos = 4'b1111; aNeg = '0; bPos = 4'b1111; bNeg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset holds outputs at zero despite live inputs
    check(sumPos == '0 && sumNeg == '0, "R7 reset result", resVal(), 0);
    check(cmpCode == 2'b00, "R7 reset sign code", int'(cmpCode), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6: new inputs do not reach the outputs before the next rising edge
    runPrime(1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);
    fieldSel = 1'b1; subEn = 1'b0;
    aPos = 4'b0011; aNeg = '0; bPos = 4'b0010; bNeg = '0;
    #5;
    check(resVal() == 0, "R6 held before edge", resVal(), 0);
    @(posedge clk);
    @(negedge clk);
    check(resVal() == 5, "R6 value after edge", resVal(), 5);
    #5;
    check(resVal() == 5, "R6 held between edges", resVal(), 5);
    @(negedge clk);

    // Corner cases: extremes and cancellation
    runPrime(1'b0, 4'b1111, 4'b0000, 4'b1111, 4'b0000);  // R1 +15 + +15
    runPrime(1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b1111);  // R1 -15 + -15
    runPrime(1'b1, 4'b1111, 4'b0000, 4'b0000, 4'b1111);  // R2 +15 - -15
    runPrime(1'b1, 4'b0101, 4'b1010, 4'b0101, 4'b1010);  // R2 equal operands -> zero

    // Exhaustive prime sweep over all legal digit patterns, both operations
    for (int op = 0; op < 2; op++) begin
      for (int ca = 0; ca < CODES; ca++) begin
        for (int cb = 0; cb < CODES; cb++) begin
          decode(ca, ap, an);
          decode(cb, bp, bn);
          runPrime(op[0], ap, an, bp, bn);
        end
      end
    end

    // Exhaustive binary-field sweep, both operations
    for (int op = 0; op < 2; op++) begin
      for (int va = 0; va < 16; va++) begin
        for (int vb = 0; vb < 16; vb++) begin
          runBinary(op[0], va[W-1:0], vb[W-1:0]);
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule